// File: doc/BRIEF.md
# UART FIFO Control Unit

This block holds the FIFO control side of a PC-style serial port. A write-only control register at port offset 3 turns the FIFOs on, requests a flush of either queue, carries a DMA mode flag and picks the receive trigger threshold. Behind it sit two byte queues, one for transmit and one for receive, each 16 entries deep. Each queue reports its occupancy, full and empty, and raises a one-cycle overrun pulse when a byte is lost.

Simple push and pop ports stand in for the serial shifter and the host. The receive-available output rises when the receive queue holds at least the selected number of bytes. When the FIFOs are off, each queue behaves as a single-byte holding register and the threshold falls to one byte. The current register contents are brought out on `ctl_value` for observation.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset `ctl_value` is 0x00, both queues are empty with count 0, and `rx_avail` is 0.
- R2: A write with `ctl_addr` = 3 stores bit 0 as FIFO enable, bit 3 as DMA mode and bits 7-6 as the trigger code. A write to any other offset leaves the stored settings unchanged.
- R3: Bits 5-4 of the written byte are ignored and always read back as 0 in `ctl_value`.
- R4: Writing 1 to bit 1 empties the receive queue in the cycle after the write and leaves the transmit queue untouched.
- R5: Writing 1 to bit 2 empties the transmit queue in the cycle after the write and leaves the receive queue untouched.
- R6: A flush bit reads as 1 in `ctl_value` for exactly one cycle after the write and then returns to 0 by itself.
- R7: A push to a queue arriving during that queue's flush cycle is discarded.
- R8: Each queue returns bytes in arrival order, holds up to 16 bytes with FIFOs on, and reports `*_full` at 16 and `*_empty` at 0 along with its count.
- R9: A push to a full queue is dropped, leaves the count unchanged and raises `*_overrun` for exactly one cycle.
- R10: A pop from an empty queue keeps the last popped byte on `*_pop_data` and changes no count.
- R11: With FIFOs on, `rx_avail` is 1 when the receive count is at least the level chosen by the trigger code: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R12: With bit 0 = 0, each queue holds one byte (full at count 1) and `rx_avail` uses a level of 1 whatever the trigger code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Register write strobe |
| ctl_addr | input | 3 | Port offset of the write |
| ctl_wdata | input | 8 | Written byte |
| ctl_value | output | 8 | Stored register contents |
| fifo_enabled | output | 1 | FIFO enable setting |
| dma_mode | output | 1 | DMA mode flag |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to push |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_pop_data | output | 8 | Last popped transmit byte |
| tx_count | output | 5 | Transmit occupancy |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_overrun | output | 1 | Transmit byte dropped (one cycle) |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_push_data | input | 8 | Byte to push |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_pop_data | output | 8 | Last popped receive byte |
| rx_count | output | 5 | Receive occupancy |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Receive byte dropped (one cycle) |
| rx_avail | output | 1 | Receive count has reached the trigger level |

## Verification
The assertions take for granted that push, pop and write strobes are clean single-cycle levels sampled at the rising edge, and that `ctl_addr` and `ctl_wdata` are valid whenever `ctl_wr` is high. The bench drives every input on the falling edge, holds each strobe for exactly one cycle, and never pushes and pops the same queue in one cycle. It pushes into a queue during that queue's flush cycle only on purpose, to show the discard, and reaches full and empty only through counted push and pop sequences.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } rx_trig_e;

    localparam int LVL_ONE      = 1;
    localparam int LVL_FOUR     = 4;
    localparam int LVL_EIGHT    = 8;
    localparam int LVL_FOURTEEN = 14;

    // Control register state, one field per stored setting
    typedef struct packed {
        rx_trig_e trig;
        logic     dma;
        logic     flush_tx;
        logic     flush_rx;
        logic     en;
    } ctl_state_t;

    function automatic int trig_to_level(input rx_trig_e code);
        case (code)
            TRIG_ONE:      return LVL_ONE;
            TRIG_FOUR:     return LVL_FOUR;
            TRIG_EIGHT:    return LVL_EIGHT;
            default:       return LVL_FOURTEEN;
        endcase
    endfunction

endpackage

// File: rtl/ufc_ctl_reg.sv
module ufc_ctl_reg
    import uart_fifo_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int CTL_OFFSET = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        reg_value,
    output logic              fifo_en,
    output logic              dma_sel,
    output rx_trig_e          trig,
    output logic              flush_rx,
    output logic              flush_tx
);

    ctl_state_t st_d, st_q;
    logic       hit;
    logic       unused_rsvd;

    assign hit         = wr && (addr == ADDR_W'(CTL_OFFSET));
    assign unused_rsvd = ^wdata[5:4];

    always_comb begin
        st_d          = st_q;
        // flush requests last one cycle only
        st_d.flush_rx = 1'b0;
        st_d.flush_tx = 1'b0;
        if (hit) begin
            st_d.en       = wdata[0];
            st_d.flush_rx = wdata[1];
            st_d.flush_tx = wdata[2];
            st_d.dma      = wdata[3];
            st_d.trig     = rx_trig_e'(wdata[7:6]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_value = {st_q.trig, 2'b00, st_q.dma, st_q.flush_tx, st_q.flush_rx, st_q.en};
    assign fifo_en   = st_q.en;
    assign dma_sel   = st_q.dma;
    assign trig      = st_q.trig;
    assign flush_rx  = st_q.flush_rx;
    assign flush_tx  = st_q.flush_tx;

    // R6: a flush request drops after one cycle unless rewritten
    p_rx_flush_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flush_rx && !hit |=> !st_q.flush_rx);
    p_tx_flush_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flush_tx && !hit |=> !st_q.flush_tx);
    // R2: settings move only on a write to the control offset
    p_offset_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable({st_q.en, st_q.dma, st_q.trig}));

endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       limit_one,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          pop_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty,
    output logic                       overrun
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                wr_ptr;
        logic [PW-1:0]                rd_ptr;
        logic [CW-1:0]                cnt;
        logic [DATA_W-1:0]            rd_data;
        logic                         ovr;
    } fifo_state_t;

    fifo_state_t   fs_d, fs_q;
    logic [CW-1:0] cap;
    logic          pop_ok;
    logic          push_ok;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign cap     = limit_one ? CW'(1) : CW'(DEPTH);
    assign full    = (fs_q.cnt >= cap);
    assign empty   = (fs_q.cnt == '0);
    assign pop_ok  = pop && !empty && !flush;
    assign push_ok = push && !flush && (!full || pop_ok);

    always_comb begin
        fs_d     = fs_q;
        fs_d.ovr = 1'b0;
        if (flush) begin
            fs_d.wr_ptr = '0;
            fs_d.rd_ptr = '0;
            fs_d.cnt    = '0;
        end else begin
            if (pop_ok) begin
                fs_d.rd_data = fs_q.mem[fs_q.rd_ptr];
                fs_d.rd_ptr  = wrap_inc(fs_q.rd_ptr);
            end
            if (push_ok) begin
                fs_d.mem[fs_q.wr_ptr] = push_data;
                fs_d.wr_ptr           = wrap_inc(fs_q.wr_ptr);
            end
            fs_d.ovr = push && !push_ok;
            fs_d.cnt = fs_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign pop_data = fs_q.rd_data;
    assign count    = fs_q.cnt;
    assign overrun  = fs_q.ovr;

    // R8: occupancy never exceeds the storage
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9: a drop pulse follows only a push into a full queue
    p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !full && push |=> !overrun);
    // R4 and R5: a flush cycle leaves the queue empty
    p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R10: popping nothing keeps the output byte
    p_empty_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty |=> $stable(pop_data));

endmodule

// File: rtl/ufc_rx_trigger.sv
module ufc_rx_trigger
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic [$clog2(DEPTH+1)-1:0] rx_count,
    input  logic                       fifo_en,
    input  rx_trig_e                   trig,
    output logic                       rx_avail
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] level;

    always_comb begin
        if (fifo_en) begin
            level = CW'(trig_to_level(trig));
        end else begin
            level = CW'(LVL_ONE);
        end
        rx_avail = (rx_count >= level);
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,
    parameter int CTL_OFFSET = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_wr,
    input  logic [ADDR_W-1:0]          ctl_addr,
    input  logic [7:0]                 ctl_wdata,
    output logic [7:0]                 ctl_value,
    output logic                       fifo_enabled,
    output logic                       dma_mode,
    input  logic                       tx_push,
    input  logic [DATA_W-1:0]          tx_push_data,
    input  logic                       tx_pop,
    output logic [DATA_W-1:0]          tx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0] tx_count,
    output logic                       tx_full,
    output logic                       tx_empty,
    output logic                       tx_overrun,
    input  logic                       rx_push,
    input  logic [DATA_W-1:0]          rx_push_data,
    input  logic                       rx_pop,
    output logic [DATA_W-1:0]          rx_pop_data,
    output logic [$clog2(DEPTH+1)-1:0] rx_count,
    output logic                       rx_full,
    output logic                       rx_empty,
    output logic                       rx_overrun,
    output logic                       rx_avail
);

    rx_trig_e trig;
    logic     flush_rx;
    logic     flush_tx;

    ufc_ctl_reg #(
        .ADDR_W     (ADDR_W),
        .CTL_OFFSET (CTL_OFFSET)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctl_wr),
        .addr      (ctl_addr),
        .wdata     (ctl_wdata),
        .reg_value (ctl_value),
        .fifo_en   (fifo_enabled),
        .dma_sel   (dma_mode),
        .trig      (trig),
        .flush_rx  (flush_rx),
        .flush_tx  (flush_tx)
    );

    ufc_byte_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_tx),
        .limit_one (!fifo_enabled),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty),
        .overrun   (tx_overrun)
    );

    ufc_byte_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush_rx),
        .limit_one (!fifo_enabled),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .overrun   (rx_overrun)
    );

    ufc_rx_trigger #(
        .DEPTH (DEPTH)
    ) u_trig (
        .rx_count (rx_count),
        .fifo_en  (fifo_enabled),
        .trig     (trig),
        .rx_avail (rx_avail)
    );

    // R11: the threshold signal never claims data in an empty queue
    p_avail_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |-> !rx_empty);
    // R12: with FIFOs off a single byte is enough
    p_disabled_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_enabled && !rx_empty |-> rx_avail);
    // R5: a transmit flush leaves the receive count alone
    p_tx_flush_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_tx && !flush_rx && !rx_push && !rx_pop |=> $stable(rx_count));

endmodule

// File: tb/uart_fifo_ctl_test.sv
module uart_fifo_ctl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_addr = '0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_value;
    logic       fifo_enabled, dma_mode;
    logic       tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_push_data = '0, tx_pop_data;
    logic [4:0] tx_count;
    logic       tx_full, tx_empty, tx_overrun;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_push_data = '0, rx_pop_data;
    logic [4:0] rx_count;
    logic       rx_full, rx_empty, rx_overrun, rx_avail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit en_m = 1'b0;
    byte unsigned rx_q[$];
    byte unsigned tx_q[$];
    bit rx_pend = 1'b0;
    bit tx_pend = 1'b0;

    always #10 clk = ~clk;

    uart_fifo_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata),
        .ctl_value(ctl_value), .fifo_enabled(fifo_enabled), .dma_mode(dma_mode),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_count(tx_count), .tx_full(tx_full),
        .tx_empty(tx_empty), .tx_overrun(tx_overrun),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_count(rx_count), .rx_full(rx_full),
        .rx_empty(rx_empty), .rx_overrun(rx_overrun), .rx_avail(rx_avail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_ctl(input logic [2:0] a, input logic [7:0] d);
        ctl_wr = 1'b1; ctl_addr = a; ctl_wdata = d;
        tick();
        ctl_wr = 1'b0;
        if (a == 3'd3) en_m = d[0];
    endtask

    task automatic push_rx(input byte unsigned d);
        rx_push = 1'b1; rx_push_data = d;
        if (rx_q.size() < (en_m ? 16 : 1)) rx_q.push_back(d);
        tick();
        rx_push = 1'b0;
    endtask

    task automatic push_tx(input byte unsigned d);
        tx_push = 1'b1; tx_push_data = d;
        if (tx_q.size() < (en_m ? 16 : 1)) tx_q.push_back(d);
        tick();
        tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1; tick(); rx_pop = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
    endtask

    // Monitor: note accepted pops at the edge, compare on the next falling edge
    always @(posedge clk) begin
        rx_pend = rx_pop && !rx_empty;
        tx_pend = tx_pop && !tx_empty;
    end

    always @(negedge clk) begin
        if (rx_pend) begin
            rx_pend = 1'b0;
            if (rx_q.size() == 0) chk("R8 rx pop with no expected byte", 1, 0);
            else chk("R8 rx order", int'(rx_pop_data), int'(rx_q.pop_front()));
        end
        if (tx_pend) begin
            tx_pend = 1'b0;
            if (tx_q.size() == 0) chk("R8 tx pop with no expected byte", 1, 0);
            else chk("R8 tx order", int'(tx_pop_data), int'(tx_q.pop_front()));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 ctl_value", int'(ctl_value), 0);
        chk("R1 rx_count", int'(rx_count), 0);
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 rx_avail", int'(rx_avail), 0);

        // R2 and R3: enable, dma, trigger 11, reserved bits set in the write
        write_ctl(3'd3, 8'hF9);
        chk("R3 reserved read as zero", int'(ctl_value), 8'hC9);
        chk("R2 dma_mode", int'(dma_mode), 1);
        chk("R2 fifo_enabled", int'(fifo_enabled), 1);
        write_ctl(3'd2, 8'h00);
        chk("R2 other offset ignored", int'(ctl_value), 8'hC9);

        // R11 level 14, R8 full, R9 overrun
        for (int i = 0; i < 13; i++) push_rx(byte'(8'h10 + i));
        chk("R11 below 14", int'(rx_avail), 0);
        push_rx(8'h1D);
        chk("R11 at 14", int'(rx_avail), 1);
        push_rx(8'h1E);
        push_rx(8'h1F);
        chk("R8 rx_full", int'(rx_full), 1);
        chk("R8 rx_count 16", int'(rx_count), 16);
        push_rx(8'h20);
        chk("R9 overrun pulse", int'(rx_overrun), 1);
        chk("R9 count kept", int'(rx_count), 16);
        tick();
        chk("R9 pulse one cycle", int'(rx_overrun), 0);
        chk("R8 tx untouched", int'(tx_count), 0);

        for (int i = 0; i < 3; i++) pop_rx();
        tick();
        chk("R8 rx_count after pops", int'(rx_count), 13);
        chk("R11 13 below 14", int'(rx_avail), 0);

        write_ctl(3'd3, 8'h01);
        chk("R11 code 00 level 1", int'(rx_avail), 1);

        // R4, R6, R7: receive flush with a push in the flush cycle
        write_ctl(3'd3, 8'h43);
        chk("R6 flush bit visible", int'(ctl_value), 8'h43);
        rx_push = 1'b1; rx_push_data = 8'hEE;
        tick();
        rx_push = 1'b0;
        rx_q.delete();
        chk("R4 rx emptied", int'(rx_count), 0);
        chk("R7 push in flush cycle discarded", int'(rx_empty), 1);
        chk("R6 flush bit cleared", int'(ctl_value), 8'h41);

        // R11 code 01 and 10
        for (int i = 0; i < 3; i++) push_rx(byte'(8'h30 + i));
        chk("R11 code 01 at 3", int'(rx_avail), 0);
        push_rx(8'h33);
        chk("R11 code 01 at 4", int'(rx_avail), 1);
        write_ctl(3'd3, 8'h81);
        chk("R11 code 10 at 4", int'(rx_avail), 0);
        for (int i = 0; i < 4; i++) push_rx(byte'(8'h34 + i));
        chk("R11 code 10 at 8", int'(rx_avail), 1);

        // R5 transmit flush
        for (int i = 0; i < 5; i++) push_tx(byte'(8'h50 + i));
        chk("R8 tx_count 5", int'(tx_count), 5);
        write_ctl(3'd3, 8'h85);
        chk("R6 tx flush bit visible", int'(ctl_value), 8'h85);
        tick();
        tx_q.delete();
        chk("R5 tx emptied", int'(tx_count), 0);
        chk("R5 rx untouched", int'(rx_count), 8);
        chk("R6 tx flush bit cleared", int'(ctl_value), 8'h81);

        // R10 pop from empty
        push_tx(8'hA1);
        push_tx(8'hA2);
        pop_tx();
        pop_tx();
        pop_tx();
        chk("R10 last byte held", int'(tx_pop_data), 8'hA2);
        chk("R10 count unchanged", int'(tx_count), 0);
        chk("R10 still empty", int'(tx_empty), 1);

        // R12 FIFOs off, trigger code 11, receive flushed
        write_ctl(3'd3, 8'hC2);
        tick();
        rx_q.delete();
        chk("R12 fifo_enabled off", int'(fifo_enabled), 0);
        chk("R12 rx flushed", int'(rx_count), 0);
        push_rx(8'h77);
        chk("R12 full at one", int'(rx_full), 1);
        chk("R12 level one", int'(rx_avail), 1);
        push_rx(8'h78);
        chk("R12 second byte dropped", int'(rx_overrun), 1);
        chk("R12 count one", int'(rx_count), 1);
        pop_rx();
        tick();
        chk("R12 empty after pop", int'(rx_empty), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule